// File: doc/BRIEF.md
# Dual Counter/Timer with Split Low/High Mode

This block holds two counter/timers, Timer 0 and Timer 1, each built from a low byte and a high byte. Each timer has a two-bit mode field: a 13-bit count (mode 0), a 16-bit count (mode 1), or an 8-bit count that reloads from the high byte (mode 2). A timer counts the system clock, the prescaled clock enable, or falling edges of an external count pin. Counting can be gated by a level taken from an external interrupt pin.

Setting Timer 0 to mode 3 splits it into two free 8-bit counters. Its low byte keeps all of Timer 0's controls and its overflow flag. Its high byte takes over Timer 1's run bit and Timer 1's overflow flag. While the split is active, Timer 1 runs or stops on its mode field alone and cannot raise its own flag. Its overflow pulse, which other blocks on the chip use as a rate source, keeps working.

Configuration arrives as plain level inputs. A byte-wide load port preloads any of the four count bytes.

Top module: `tmr_pair`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both 16-bit counts, both overflow flags and the overflow pulse read zero.
- R2: In mode 1 a timer counts as one 16-bit value {high,low}; each tick adds one, and a tick at 0xFFFF wraps it to 0x0000 and sets the timer's flag.
- R3: In mode 0 only the five lower bits of the low byte count. When they wrap from 31 to 0 the high byte steps by one, and the upper three bits of the low byte do not change. The flag is set when the high byte is 0xFF and the five bits are 31.
- R4: In mode 2 the low byte counts alone. A tick at 0xFF copies the high byte into the low byte and sets the flag; the high byte never changes.
- R5: With its counter select at 1, a timer ticks once for each falling edge of `cnt_pin`, seen after a SYNC-stage synchronizer and one edge-detect register. With the select at 0, it ticks every clock when its clock select is 1, and only in cycles with `presc_en` high when its clock select is 0.
- R6: When a timer's gate bit is 1 (and it is not in split operation), it counts only while the synchronized `irq_pin` XOR `irq_inv` is 1.
- R7: With Timer 0 mode 3, the Timer 0 low byte is an 8-bit counter under Timer 0's run, counter select, gate and clock select. Its wrap from 0xFF to 0x00 sets the Timer 0 flag and does not touch the high byte.
- R8: With Timer 0 mode 3, the Timer 0 high byte ticks only while `t1_run` is 1. It counts at the rate set by `t1_clksel`, never from `cnt_pin`, and ignores both gates. Its wrap from 0xFF sets the Timer 1 flag.
- R9: With Timer 0 mode 3, Timer 1 counts the clock picked by `t1_clksel` whenever its mode is 0, 1 or 2, and stops in mode 3. It ignores `t1_run`, `t1_ct` and `t1_gate`, and its overflow never sets the Timer 1 flag.
- R10: `t1_ovf_pulse` is high for exactly the cycle after each Timer 1 overflow, whether or not Timer 0 is split.
- R11: When Timer 0 is not split, Timer 1 in mode 3 holds its count even when `t1_run` is 1.
- R12: A flag stays set until its clear input is high at a clock edge. A set and a clear in the same cycle leave the flag set.
- R13: With `ld_en` high, `ld_data` is written into the byte picked by `ld_sel`: 0 is Timer 0 low, 1 is Timer 0 high, 2 is Timer 1 low, 3 is Timer 1 high. The timer being written does not count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_en | input | 1 | Prescaled clock enable, one cycle per prescaled tick |
| cnt_pin | input | 1 | External count input, falling edges counted |
| irq_pin | input | 1 | External interrupt pin used as gate source |
| irq_inv | input | 1 | Polarity select XORed with the synchronized pin |
| t0_mode | input | 2 | Timer 0 mode (3 = split) |
| t0_run | input | 1 | Timer 0 run |
| t0_ct | input | 1 | Timer 0 counter select (1 = external pin) |
| t0_gate | input | 1 | Timer 0 gate enable |
| t0_clksel | input | 1 | Timer 0 clock select (1 = system clock) |
| t1_mode | input | 2 | Timer 1 mode |
| t1_run | input | 1 | Timer 1 run, or Timer 0 high-byte run when split |
| t1_ct | input | 1 | Timer 1 counter select |
| t1_gate | input | 1 | Timer 1 gate enable |
| t1_clksel | input | 1 | Timer 1 clock select, also used by the split high byte |
| t0_flag_clr | input | 1 | Clears the Timer 0 flag |
| t1_flag_clr | input | 1 | Clears the Timer 1 flag |
| ld_en | input | 1 | Byte load strobe |
| ld_sel | input | 2 | Byte to load |
| ld_data | input | 8 | Load value |
| t0_cnt | output | 16 | Timer 0 count {high, low} |
| t1_cnt | output | 16 | Timer 1 count {high, low} |
| t0_flag | output | 1 | Timer 0 overflow flag |
| t1_flag | output | 1 | Timer 1 overflow flag |
| t1_ovf_pulse | output | 1 | One-cycle Timer 1 overflow pulse |

## Verification
The counts are driven by the free-running clock, by a sparse prescale enable, and by toggles of the external pin. Comparing these three sources separates the clock-select and counter-select paths and shows the latency of the synchronizer. The gate is exercised with the pin both high and low and with the polarity bit both set and clear, which shows whether the XOR is present. In split operation, `t1_run`, `t1_ct` and `t1_gate` are set against their expected effect while Timer 1 overflows and the high byte wraps. This separates the source of the Timer 1 flag from the source of the Timer 1 pulse. Mode 0 and mode 2 preloads are chosen near wrap, so the masked bits and the reload value are visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TM_PRE13   = 2'd0,
        TM_WIDE16  = 2'd1,
        TM_RELOAD8 = 2'd2,
        TM_SPLIT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic f0;
        logic f1;
        logic pulse;
    } tmr_flag_st_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_pin,
    input  logic irq_pin,
    output logic cnt_fall,
    output logic irq_lvl
);

    typedef struct packed {
        logic [STAGES-1:0] c;
        logic [STAGES-1:0] i;
        logic              c_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.c[0] = cnt_pin;
        st_d.i[0] = irq_pin;
        for (int k = 1; k < STAGES; k++) begin
            st_d.c[k] = st_q.c[k-1];
            st_d.i[k] = st_q.i[k-1];
        end
        st_d.c_prev = st_q.c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_fall = st_q.c_prev & ~st_q.c[STAGES-1];
    assign irq_lvl  = st_q.i[STAGES-1];

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W   = 8,
    parameter int PRE = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         split,
    input  logic         tick_lo,
    input  logic         tick_hi,
    input  logic         ld_lo,
    input  logic         ld_hi,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         ovf_lo,
    output logic         ovf_hi
);

    localparam logic [W-1:0]   ONES  = '1;
    localparam logic [PRE-1:0] PONES = '1;
    localparam logic [W-1:0]   ONE   = W'(1);
    localparam logic [PRE-1:0] PONE  = PRE'(1);
    localparam logic [2*W-1:0] ONE2  = (2*W)'(1);

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (ld_lo || ld_hi) begin
            if (ld_lo) st_d.lo = ld_data;
            if (ld_hi) st_d.hi = ld_data;
        end else if (split) begin
            if (tick_lo) begin
                st_d.lo = st_q.lo + ONE;
                ovf_lo  = (st_q.lo == ONES);
            end
            if (tick_hi) begin
                st_d.hi = st_q.hi + ONE;
                ovf_hi  = (st_q.hi == ONES);
            end
        end else if (tick_lo) begin
            case (tmr_mode_e'(mode))
                TM_PRE13: begin
                    st_d.lo[PRE-1:0] = st_q.lo[PRE-1:0] + PONE;
                    if (st_q.lo[PRE-1:0] == PONES) begin
                        st_d.hi = st_q.hi + ONE;
                        ovf_lo  = (st_q.hi == ONES);
                    end
                end
                TM_WIDE16: begin
                    {st_d.hi, st_d.lo} = {st_q.hi, st_q.lo} + ONE2;
                    ovf_lo = (st_q.hi == ONES) && (st_q.lo == ONES);
                end
                TM_RELOAD8: begin
                    if (st_q.lo == ONES) begin
                        st_d.lo = st_q.hi;
                        ovf_lo  = 1'b1;
                    end else begin
                        st_d.lo = st_q.lo + ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo = st_q.lo;
    assign hi = st_q.hi;

    // R4: reload copies the high byte into the low byte
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && mode == 2'd2 && tick_lo && !ld_lo && !ld_hi && lo == ONES)
        |=> (lo == $past(hi)));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter int PRE  = 5,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           presc_en,
    input  logic           cnt_pin,
    input  logic           irq_pin,
    input  logic           irq_inv,
    input  logic [1:0]     t0_mode,
    input  logic           t0_run,
    input  logic           t0_ct,
    input  logic           t0_gate,
    input  logic           t0_clksel,
    input  logic [1:0]     t1_mode,
    input  logic           t1_run,
    input  logic           t1_ct,
    input  logic           t1_gate,
    input  logic           t1_clksel,
    input  logic           t0_flag_clr,
    input  logic           t1_flag_clr,
    input  logic           ld_en,
    input  logic [1:0]     ld_sel,
    input  logic [W-1:0]   ld_data,
    output logic [2*W-1:0] t0_cnt,
    output logic [2*W-1:0] t1_cnt,
    output logic           t0_flag,
    output logic           t1_flag,
    output logic           t1_ovf_pulse
);

    logic cnt_fall, irq_lvl, gate_lvl;
    logic split, t1_mode_run;
    logic clk_tick0, clk_tick1;
    logic tick0_lo, tick0_hi, tick1;
    logic ld0_lo, ld0_hi, ld1_lo, ld1_hi;
    logic ovf0_lo, ovf0_hi, ovf1_lo, ovf1_hi, ovf1;
    logic [W-1:0] t0_lo, t0_hi, t1_lo, t1_hi;

    tmr_flag_st_t st_d, st_q;

    tmr_sync #(.STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_pin  (cnt_pin),
        .irq_pin  (irq_pin),
        .cnt_fall (cnt_fall),
        .irq_lvl  (irq_lvl)
    );

    always_comb begin
        gate_lvl    = irq_lvl ^ irq_inv;
        split       = (tmr_mode_e'(t0_mode) == TM_SPLIT);
        t1_mode_run = (tmr_mode_e'(t1_mode) != TM_SPLIT);
        clk_tick0   = t0_clksel | presc_en;
        clk_tick1   = t1_clksel | presc_en;

        tick0_lo = t0_run & (~t0_gate | gate_lvl) & (t0_ct ? cnt_fall : clk_tick0);
        tick0_hi = split & t1_run & clk_tick1;

        if (split)
            tick1 = t1_mode_run & clk_tick1;
        else
            tick1 = t1_mode_run & t1_run & (~t1_gate | gate_lvl)
                  & (t1_ct ? cnt_fall : clk_tick1);

        ld0_lo = ld_en && (ld_sel == 2'd0);
        ld0_hi = ld_en && (ld_sel == 2'd1);
        ld1_lo = ld_en && (ld_sel == 2'd2);
        ld1_hi = ld_en && (ld_sel == 2'd3);
    end

    tmr_core #(.W(W), .PRE(PRE)) u_t0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (t0_mode),
        .split   (split),
        .tick_lo (tick0_lo),
        .tick_hi (tick0_hi),
        .ld_lo   (ld0_lo),
        .ld_hi   (ld0_hi),
        .ld_data (ld_data),
        .lo      (t0_lo),
        .hi      (t0_hi),
        .ovf_lo  (ovf0_lo),
        .ovf_hi  (ovf0_hi)
    );

    tmr_core #(.W(W), .PRE(PRE)) u_t1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (t1_mode),
        .split   (1'b0),
        .tick_lo (tick1),
        .tick_hi (1'b0),
        .ld_lo   (ld1_lo),
        .ld_hi   (ld1_hi),
        .ld_data (ld_data),
        .lo      (t1_lo),
        .hi      (t1_hi),
        .ovf_lo  (ovf1_lo),
        .ovf_hi  (ovf1_hi)
    );

    always_comb begin
        ovf1     = ovf1_lo | ovf1_hi;
        st_d     = st_q;
        st_d.f0  = (st_q.f0 & ~t0_flag_clr) | ovf0_lo;
        st_d.f1  = (st_q.f1 & ~t1_flag_clr) | (split ? ovf0_hi : ovf1);
        st_d.pulse = ovf1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t0_cnt       = {t0_hi, t0_lo};
    assign t1_cnt       = {t1_hi, t1_lo};
    assign t0_flag      = st_q.f0;
    assign t1_flag      = st_q.f1;
    assign t1_ovf_pulse = st_q.pulse;

    // R6: a closed gate freezes Timer 0
    p_gate_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && t0_gate && !gate_lvl && !ld_en) |=> $stable(t0_cnt));

    // R8: split high byte idles without the Timer 1 run bit
    p_hi_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !t1_run && !ld_en) |=> $stable(t0_hi));

    // R9: in split operation only the high byte may raise the Timer 1 flag
    p_split_t1flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !t1_flag && !ovf0_hi) |=> !t1_flag);

    // R10: a pulse after a 16-bit Timer 1 count leaves it at zero
    p_pulse_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_ovf_pulse && $past(t1_mode) == 2'd1 && !$past(ld_en)) |-> (t1_cnt == '0));

    // R11: Timer 1 in mode 3 holds while Timer 0 is whole
    p_t1_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && t1_mode == 2'd3 && !ld_en) |=> $stable(t1_cnt));

    // R12: a flag without a clear stays set
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_flag && !t0_flag_clr) |=> t0_flag);

endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;

    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        presc_en = 0, cnt_pin = 0, irq_pin = 0, irq_inv = 0;
    logic [1:0]  t0_mode = 2'd1, t1_mode = 2'd1;
    logic        t0_run = 0, t0_ct = 0, t0_gate = 0, t0_clksel = 0;
    logic        t1_run = 0, t1_ct = 0, t1_gate = 0, t1_clksel = 0;
    logic        t0_flag_clr = 0, t1_flag_clr = 0;
    logic        ld_en = 0;
    logic [1:0]  ld_sel = 0;
    logic [7:0]  ld_data = 0;
    logic [15:0] t0_cnt, t1_cnt;
    logic        t0_flag, t1_flag, t1_ovf_pulse;

    int errs = 0, checks = 0, cyc = 0;
    string cur_req = "R1";
    bit compare_on = 0;

    always #2 clk = ~clk;

    tmr_pair #(.W(8), .PRE(5), .SYNC(S)) i_tmr_pair (
        .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .cnt_pin(cnt_pin),
        .irq_pin(irq_pin), .irq_inv(irq_inv),
        .t0_mode(t0_mode), .t0_run(t0_run), .t0_ct(t0_ct), .t0_gate(t0_gate),
        .t0_clksel(t0_clksel),
        .t1_mode(t1_mode), .t1_run(t1_run), .t1_ct(t1_ct), .t1_gate(t1_gate),
        .t1_clksel(t1_clksel),
        .t0_flag_clr(t0_flag_clr), .t1_flag_clr(t1_flag_clr),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .t0_cnt(t0_cnt), .t1_cnt(t1_cnt), .t0_flag(t0_flag), .t1_flag(t1_flag),
        .t1_ovf_pulse(t1_ovf_pulse)
    );

    // reference model state
    logic [15:0] m_c0, m_c1;
    logic        m_f0, m_f1, m_p;
    logic [S:0]  h_cnt, h_irq;

    // one step of a whole timer: {overflow, new value}
    function automatic logic [16:0] step(input logic [1:0] md, input logic [15:0] v);
        int lo5, hi, lo;
        hi  = v[15:8];
        lo  = v[7:0];
        lo5 = lo % 32;
        case (md)
            2'd0: begin
                if (lo5 == 31)
                    return {hi == 255, 8'((hi + 1) % 256), 8'(lo - 31)};
                return {1'b0, v[15:8], 8'(lo + 1)};
            end
            2'd1: return {v == 16'hFFFF, 16'(v + 1)};
            2'd2: begin
                if (lo == 255) return {1'b1, v[15:8], v[15:8]};
                return {1'b0, v[15:8], 8'(lo + 1)};
            end
            default: return {1'b0, v};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c0 = 0; m_c1 = 0; m_f0 = 0; m_f1 = 0; m_p = 0;
            h_cnt = 0; h_irq = 0;
        end else begin
            logic fall, lvl, sp, tk0, tkh, tk1, o0, oh, o1;
            logic [16:0] r;
            fall = h_cnt[S] & ~h_cnt[S-1];
            lvl  = h_irq[S-1] ^ irq_inv;
            sp   = (t0_mode == 2'd3);
            tk0  = t0_run && (!t0_gate || lvl) && (t0_ct ? fall : (t0_clksel || presc_en));
            tkh  = sp && t1_run && (t1_clksel || presc_en);
            if (sp) tk1 = (t1_mode != 2'd3) && (t1_clksel || presc_en);
            else    tk1 = (t1_mode != 2'd3) && t1_run && (!t1_gate || lvl)
                          && (t1_ct ? fall : (t1_clksel || presc_en));
            o0 = 0; oh = 0; o1 = 0;
            if (ld_en && ld_sel < 2) begin
                if (ld_sel == 0) m_c0[7:0] = ld_data; else m_c0[15:8] = ld_data;
            end else if (sp) begin
                if (tk0) begin o0 = (m_c0[7:0] == 8'hFF); m_c0[7:0] = m_c0[7:0] + 8'd1; end
                if (tkh) begin oh = (m_c0[15:8] == 8'hFF); m_c0[15:8] = m_c0[15:8] + 8'd1; end
            end else if (tk0) begin
                r = step(t0_mode, m_c0); o0 = r[16]; m_c0 = r[15:0];
            end
            if (ld_en && ld_sel >= 2) begin
                if (ld_sel == 2) m_c1[7:0] = ld_data; else m_c1[15:8] = ld_data;
            end else if (tk1) begin
                r = step(t1_mode, m_c1); o1 = r[16]; m_c1 = r[15:0];
            end
            m_f0 = (m_f0 && !t0_flag_clr) || o0;
            m_f1 = (m_f1 && !t1_flag_clr) || (sp ? oh : o1);
            m_p  = o1;
            h_cnt = {h_cnt[S-1:0], cnt_pin};
            h_irq = {h_irq[S-1:0], irq_pin};
        end
    end

    task automatic chk(input string req, input logic ok, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk(cur_req, t0_cnt == m_c0, "t0_cnt", t0_cnt, m_c0);
            chk(cur_req, t1_cnt == m_c1, "t1_cnt", t1_cnt, m_c1);
            chk(cur_req, {t0_flag, t1_flag, t1_ovf_pulse} == {m_f0, m_f1, m_p},
                "flags{f0,f1,pulse}", 16'({t0_flag, t1_flag, t1_ovf_pulse}),
                16'({m_f0, m_f1, m_p}));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [1:0] s, input logic [7:0] d);
        ld_en = 1; ld_sel = s; ld_data = d;
        @(negedge clk);
        ld_en = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errs++; checks++;
                $display("FAIL watchdog expired in %s", cur_req);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        cycles(3);
        // R1: reset state, during and just after reset
        chk("R1", t0_cnt == 0 && t1_cnt == 0, "counts in reset", t0_cnt | t1_cnt, 16'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", {t0_flag, t1_flag, t1_ovf_pulse} == 3'b000, "flags after reset",
            16'({t0_flag, t1_flag, t1_ovf_pulse}), 16'h0);
        chk("R1", t0_cnt == 0 && t1_cnt == 0, "counts after reset", t0_cnt | t1_cnt, 16'h0);
        compare_on = 1;

        cur_req = "R13";
        load(2'd0, 8'hF0); load(2'd1, 8'hFF); load(2'd2, 8'h12); load(2'd3, 8'h34);
        chk("R13", t0_cnt == 16'hFFF0 && t1_cnt == 16'h3412, "loaded bytes", t0_cnt, 16'hFFF0);
        t0_clksel = 1; t0_run = 1;
        load(2'd2, 8'h40);   // the loaded timer holds; the other keeps counting
        cycles(2);

        cur_req = "R2";
        load(2'd0, 8'hF0); load(2'd1, 8'hFF);
        cycles(20);
        chk("R2", t0_flag == 1'b1, "t0 flag after 16-bit wrap", 16'(t0_flag), 16'h1);
        t0_run = 0;

        cur_req = "R12";
        t0_flag_clr = 1; cycles(1); t0_flag_clr = 0;
        chk("R12", t0_flag == 1'b0, "t0 flag after clear", 16'(t0_flag), 16'h0);
        cycles(3);
        load(2'd0, 8'hFE);
        t0_flag_clr = 1; t0_run = 1;
        cycles(5);
        t0_flag_clr = 0; t0_run = 0;
        cycles(1);

        cur_req = "R5";
        t1_mode = 2'd1; t1_clksel = 0; t1_run = 1;
        load(2'd2, 8'hF0); load(2'd3, 8'hFF);
        for (int i = 0; i < 60; i++) begin
            presc_en = (i % 3 == 0);
            cycles(1);
        end
        presc_en = 0; t1_run = 0;
        t0_ct = 1; t0_run = 1;
        load(2'd0, 8'hFC); load(2'd1, 8'h00);
        for (int i = 0; i < 8; i++) begin
            cnt_pin = 1; cycles(3);
            cnt_pin = 0; cycles(4);
        end
        t0_ct = 0; t0_run = 0;
        cycles(4);

        cur_req = "R6";
        t0_gate = 1; t0_run = 1; t0_clksel = 1;
        irq_pin = 0; cycles(6);
        irq_pin = 1; cycles(6);
        irq_inv = 1; cycles(6);
        irq_pin = 0; cycles(6);
        t0_gate = 0; t0_run = 0; irq_inv = 0;
        cycles(2);

        cur_req = "R3";
        t0_mode = 2'd0;
        load(2'd0, 8'hFC); load(2'd1, 8'hFF);
        t0_run = 1; cycles(10); t0_run = 0;
        load(2'd0, 8'hE0); load(2'd1, 8'h00);
        t0_run = 1; cycles(40); t0_run = 0;
        cycles(1);

        cur_req = "R4";
        t1_mode = 2'd2; t1_clksel = 1;
        load(2'd2, 8'hFD); load(2'd3, 8'hFB);
        t1_run = 1; cycles(20); t1_run = 0;
        cycles(1);

        cur_req = "R11";
        t1_mode = 2'd3; t1_run = 1; cycles(10); t1_run = 0;

        cur_req = "R9";
        t1_flag_clr = 1; cycles(1); t1_flag_clr = 0;
        t0_mode = 2'd3; t1_mode = 2'd1; t1_ct = 1; t1_gate = 1;
        load(2'd2, 8'hF8); load(2'd3, 8'hFF);
        cycles(20);
        chk("R9", t1_flag == 1'b0, "t1 flag stays clear in split", 16'(t1_flag), 16'h0);

        cur_req = "R7";
        load(2'd0, 8'hF0); load(2'd1, 8'h00);
        t0_run = 1; t0_clksel = 1; cycles(24); t0_run = 0;

        cur_req = "R8";
        load(2'd1, 8'hF8);
        t1_run = 1; t1_clksel = 0;
        for (int i = 0; i < 40; i++) begin
            presc_en = (i % 2 == 0);
            cnt_pin = (i % 4 < 2);
            cycles(1);
        end
        presc_en = 0; cnt_pin = 0;
        chk("R8", t1_flag == 1'b1, "t1 flag from high byte wrap", 16'(t1_flag), 16'h1);
        t1_run = 0; cycles(5);

        cur_req = "R10";
        t1_mode = 2'd2; t1_clksel = 1;
        load(2'd2, 8'hFA); load(2'd3, 8'hF8);
        cycles(20);
        cur_req = "R9";
        t1_mode = 2'd3; cycles(10);

        cur_req = "R12";
        t1_flag_clr = 1; cycles(1); t1_flag_clr = 0;
        t0_mode = 2'd1; t1_mode = 2'd1; t1_ct = 0; t1_gate = 0;
        cycles(5);

        compare_on = 0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule